// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Core

This block is a compact 32-bit load/store processor. Each instruction runs over several clock cycles, one functional step per cycle. Instructions and data live in the same memory, which is reached through one word-addressed port. A single ALU does all of the arithmetic: it computes register results, memory addresses, the incremented program counter and branch targets. Holding registers between the steps carry values from one cycle to the next: the instruction register, the memory data register, the two operand registers and the ALU result register.

A control state machine moves through fetch, decode, execute, memory access and write-back. An instruction uses only the steps it needs, and the machine goes back to fetch after its last step. The memory sits outside the block. It must return read data in the same cycle as the address (asynchronous read) and take a write on the clock edge while the write enable is high.

Instruction fields: opcode = bits [31:26], first source register = [25:21], second source/load target = [20:16], destination = [15:11], function code = [5:0], immediate = [15:0] (sign-extended), jump target = [25:0].

Top module: `mcp_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the core presents word address 0 with read enable high and write enable low. The first instruction is fetched from byte address 0.
- R2: Instructions that do not branch or jump are fetched from consecutive word addresses. The PC advances by 4 bytes in every fetch cycle.
- R3: A load (opcode 0x23) reads the word at base register + immediate and writes it to the register in [20:16]. It takes exactly 5 cycles from its fetch to the next fetch.
- R4: A store (opcode 0x2B) writes the register in [20:16] to base register + immediate, with one write-enable cycle. It takes exactly 4 cycles.
- R5: A register-register operation (opcode 0x00) writes the result to the register in [15:11] and takes 4 cycles. The function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed set-less-than, which gives 1 or 0.
- R6: A branch-if-equal (opcode 0x04) takes 3 cycles. When both source registers are equal, the next fetch is at PC+4+(immediate<<2). Otherwise it is at PC+4.
- R7: A jump (opcode 0x02) takes 3 cycles. The next fetch is at {PC[31:28], target, 2'b00}, where PC[31:28] is taken after the fetch-step increment.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: Read enable and write enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address, taken from the PC or from the ALU result register |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_re | output | 1 | Read enable (fetch or load) |
| mem_we | output | 1 | Write enable (store) |

## Verification
Branch and jump targets depend on values that the core computes internally. The branch target is formed during decode, before the comparison is known, and is then used or thrown away. The program therefore includes a not-taken branch, a taken forward branch over stores that must never happen, a jump over more such stores, and a backward branch onto itself that makes the core spin. Any mistake in a target shows up as a wrong fetch address or as an unexpected store. Every fetch is also timed against the cycle count of the instruction before it, which brings out the per-class step sequences. A write to register 0, followed by a store of register 0 over a non-zero word, shows at the memory port whether that write had any effect.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RR  = 6'h00;
  localparam logic [5:0] OPC_JMP = 6'h02;
  localparam logic [5:0] OPC_BEQ = 6'h04;
  localparam logic [5:0] OPC_LD  = 6'h23;
  localparam logic [5:0] OPC_ST  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDRD, S_LDWB,
    S_STWR, S_EXEC, S_ALUWB, S_BEQ, S_JMP
  } step_t;

  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} aluop_t;

  // second operand choices: operand reg, constant four, immediate, immediate*4
  typedef enum logic [1:0] {B_REG, B_FOUR, B_IMM, B_IMM4} srcb_t;

  typedef enum logic [1:0] {PC_ALU, PC_HELD, PC_JMP} pcsrc_t;

  typedef struct packed {
    logic   pc_we;
    pcsrc_t pc_src;
    logic   br;
    logic   iord;
    logic   mem_re;
    logic   mem_we;
    logic   ir_we;
    logic   reg_we;
    logic   dst_rd;
    logic   wb_mem;
    logic   a_from_reg;
    srcb_t  src_b;
    aluop_t alu_op;
  } ctl_t;
endpackage

// File: rtl/mcp_alu.sv
module mcp_alu
  import mcp_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  aluop_t        op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_SLT:  y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra1,
  input  logic [RW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output step_t      state
);
  step_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OPC_LD, OPC_ST: nxt = S_ADDR;
          OPC_RR:         nxt = S_EXEC;
          OPC_BEQ:        nxt = S_BEQ;
          OPC_JMP:        nxt = S_JMP;
          default:        nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (opcode == OPC_LD) ? S_LDRD : S_STWR;
      S_LDRD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_ALUWB;
      default:  nxt = S_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state)
      S_FETCH: begin
        ctl.mem_re = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.src_b  = B_FOUR;
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PC_ALU;
      end
      S_DECODE: ctl.src_b = B_IMM4;
      S_ADDR: begin
        ctl.a_from_reg = 1'b1;
        ctl.src_b      = B_IMM;
      end
      S_LDRD: begin
        ctl.iord   = 1'b1;
        ctl.mem_re = 1'b1;
      end
      S_LDWB: begin
        ctl.reg_we = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      S_STWR: begin
        ctl.iord   = 1'b1;
        ctl.mem_we = 1'b1;
      end
      S_EXEC: begin
        ctl.a_from_reg = 1'b1;
        ctl.src_b      = B_REG;
        case (funct)
          FN_SUB:  ctl.alu_op = OP_SUB;
          FN_AND:  ctl.alu_op = OP_AND;
          FN_OR:   ctl.alu_op = OP_OR;
          FN_SLT:  ctl.alu_op = OP_SLT;
          default: ctl.alu_op = OP_ADD;
        endcase
      end
      S_ALUWB: begin
        ctl.reg_we = 1'b1;
        ctl.dst_rd = 1'b1;
      end
      S_BEQ: begin
        ctl.a_from_reg = 1'b1;
        ctl.src_b      = B_REG;
        ctl.alu_op     = OP_SUB;
        ctl.br         = 1'b1;
        ctl.pc_src     = PC_HELD;
      end
      S_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PC_JMP;
      end
      default: ;
    endcase
  end

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_DECODE)); // R2
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (state == S_LDRD) |=> (state == S_LDWB && ctl.reg_we)); // R3
  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (state == S_STWR) |=> (state == S_FETCH)); // R4
endmodule

// File: rtl/mcp_core.sv
module mcp_core
  import mcp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              mem_re,
  output logic              mem_we
);
  localparam int RW = $clog2(NREG);

  ctl_t  ctl;
  step_t state;

  logic [XLEN-1:0] pc, ir, mdr, a_q, b_q, alu_q;
  logic [XLEN-1:0] op_a, op_b, alu_y, imm_se, pc_next, byte_addr, wb_data;
  logic [XLEN-1:0] rf_a, rf_b;
  logic            zero, pc_write;
  logic [RW-1:0]   wr_idx;

  mcp_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir[31:26]),
    .funct  (ir[5:0]),
    .ctl    (ctl),
    .state  (state)
  );

  assign imm_se = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign op_a   = ctl.a_from_reg ? a_q : pc;

  always_comb begin
    case (ctl.src_b)
      B_REG:   op_b = b_q;
      B_FOUR:  op_b = 32'd4;
      B_IMM:   op_b = imm_se;
      default: op_b = {imm_se[XLEN-3:0], 2'b00};
    endcase
  end

  mcp_alu u_alu (
    .a    (op_a),
    .b    (op_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (zero)
  );

  always_comb begin
    case (ctl.pc_src)
      PC_HELD: pc_next = alu_q;
      PC_JMP:  pc_next = {pc[31:28], ir[25:0], 2'b00};
      default: pc_next = alu_y;
    endcase
  end

  assign pc_write = ctl.pc_we | (ctl.br & zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (pc_write)  pc <= pc_next;
      if (ctl.ir_we) ir <= mem_rdata;
    end
  end

  // single-cycle holding registers, no enables
  always_ff @(posedge clk) begin
    if (rst) begin
      mdr   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
    end else begin
      mdr   <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alu_q <= alu_y;
    end
  end

  assign wr_idx  = ctl.dst_rd ? ir[11 +: RW] : ir[16 +: RW];
  assign wb_data = ctl.wb_mem ? mdr : alu_q;

  mcp_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk   (clk),
    .we    (ctl.reg_we),
    .waddr (wr_idx),
    .wdata (wb_data),
    .ra1   (ir[21 +: RW]),
    .ra2   (ir[16 +: RW]),
    .rd1   (rf_a),
    .rd2   (rf_b)
  );

  assign byte_addr = ctl.iord ? alu_q : pc;
  assign mem_addr  = byte_addr[ADDR_W+1:2];
  assign mem_wdata = b_q;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;

  logic unused_bits;
  assign unused_bits = ^{ir[10:6], byte_addr[1:0], byte_addr[XLEN-1:ADDR_W+2]};

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc == $past(pc) + 32'd4)); // R2
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == S_BEQ && !zero) |=> $stable(pc)); // R6
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (state == S_JMP) |=> (pc[1:0] == 2'b00 && pc[31:28] == $past(pc[31:28]))); // R7
endmodule

// File: tb/test_mcp_core.sv
module test_mcp_core;
  localparam int AW = 10;
  localparam int PROG_END = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          mem_re, mem_we;

  logic [31:0] mem [1<<AW];
  logic [63:0] fetch_q [$];
  logic [63:0] store_q [$];

  int tests = 0, fails = 0, cyc = 0, last_fetch = -1;
  bit clash = 1'b0, fetch_done = 1'b0;

  always #5 clk = ~clk;

  mcp_core #(.ADDR_W(AW)) i_mcp_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] imm_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic exp_fetch(input int word, input int delta);
    fetch_q.push_back({word[31:0], delta[31:0]});
  endtask
  task automatic exp_store(input int word, input logic [31:0] data);
    store_q.push_back({word[31:0], data});
  endtask

  // monitor: pops expected fetches and stores as the core produces them
  always @(negedge clk) begin
    if (rst) begin
      if (mem_we) clash = 1'b1;
    end else begin
      if (mem_re && mem_we) clash = 1'b1;
      if (mem_re && !mem_we && mem_addr < PROG_END && !fetch_done) begin
        logic [63:0] e;
        if (fetch_q.size() == 0) fetch_done = 1'b1;
        else begin
          e = fetch_q.pop_front();
          check("R2/R6/R7 fetch address", {54'd0, mem_addr}, {32'd0, e[63:32]});
          if (e[31:0] != 0)
            check("R3/R4/R5/R6/R7 cycles per instruction", cyc - last_fetch, e[31:0]);
          last_fetch = cyc;
          if (fetch_q.size() == 0) fetch_done = 1'b1;
        end
      end
      if (mem_we) begin
        if (store_q.size() == 0) check("R4 unexpected store", {22'd0, mem_addr, mem_wdata}, 64'd0);
        else check("R4 store address/data", {22'd0, mem_addr, mem_wdata}, store_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'd0;
    mem[0]  = imm_i(6'h23, 0, 1, 16'h0400);      // ld r1
    mem[1]  = imm_i(6'h23, 0, 2, 16'h0404);      // ld r2
    mem[2]  = rr(1, 2, 3, 6'h20);                // add
    mem[3]  = imm_i(6'h2B, 0, 3, 16'h0408);
    mem[4]  = rr(2, 1, 4, 6'h22);                // sub
    mem[5]  = imm_i(6'h2B, 0, 4, 16'h040C);
    mem[6]  = rr(1, 2, 5, 6'h24);                // and
    mem[7]  = rr(1, 2, 6, 6'h25);                // or
    mem[8]  = rr(1, 2, 7, 6'h2A);                // slt
    mem[9]  = imm_i(6'h2B, 0, 7, 16'h0410);
    mem[10] = rr(1, 2, 0, 6'h20);                // write r0
    mem[11] = imm_i(6'h2B, 0, 0, 16'h0414);
    mem[12] = imm_i(6'h04, 1, 2, 16'h0005);      // not taken
    mem[13] = imm_i(6'h04, 1, 1, 16'h0002);      // taken to 16
    mem[14] = imm_i(6'h2B, 0, 1, 16'h0418);
    mem[15] = imm_i(6'h2B, 0, 1, 16'h0418);
    mem[16] = {6'h02, 26'd20};                   // jump to 20
    for (int i = 17; i < 20; i++) mem[i] = imm_i(6'h2B, 0, 2, 16'h041C);
    mem[20] = imm_i(6'h2B, 0, 6, 16'h041C);
    mem[21] = imm_i(6'h2B, 0, 5, 16'h0420);
    mem[22] = imm_i(6'h04, 0, 0, 16'hFFFF);      // spin on itself
    mem[256] = 32'h0000_0011;
    mem[257] = 32'h0000_0022;
    mem[261] = 32'h0000_DEAD;
    mem[264] = 32'h0000_BEEF;

    exp_fetch(0, 0);  exp_fetch(1, 5);  exp_fetch(2, 5);  exp_fetch(3, 4);
    exp_fetch(4, 4);  exp_fetch(5, 4);  exp_fetch(6, 4);  exp_fetch(7, 4);
    exp_fetch(8, 4);  exp_fetch(9, 4);  exp_fetch(10, 4); exp_fetch(11, 4);
    exp_fetch(12, 4); exp_fetch(13, 3); exp_fetch(16, 3); exp_fetch(20, 3);
    exp_fetch(21, 4); exp_fetch(22, 4); exp_fetch(22, 3); exp_fetch(22, 3);
    exp_store(258, 32'h33);   // R5 add
    exp_store(259, 32'h11);   // R5 sub
    exp_store(260, 32'h1);    // R5 slt
    exp_store(261, 32'h0);    // R8 r0 stays zero
    exp_store(263, 32'h33);   // R5 or, R7 jump landed
    exp_store(264, 32'h0);    // R5 and

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset address", {54'd0, mem_addr}, 64'd0);
    check("R1 reset read enable", {63'd0, mem_re}, 64'd1);
    check("R1 reset write enable", {63'd0, mem_we}, 64'd0);
    @(posedge clk);
    rst <= 1'b0;

    for (int w = 0; w < 3000 && !fetch_done; w++) @(posedge clk);
    repeat (2) @(negedge clk);
    if (!fetch_done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    check("R4 all stores seen", store_q.size(), 64'd0);
    check("R9 no read/write overlap", {63'd0, clash}, 64'd0);
    check("R3 load source kept", mem[256], 64'h11);
    check("R6 skipped store absent", mem[262], 64'h0);
    check("R8 r0 store result", mem[261], 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule